// File: doc/BRIEF.md
# Serial EEPROM Block-Read Controller

This block fetches a run of consecutive 16-bit words from a three-wire serial EEPROM (chip select, serial clock, serial data each way) and hands each word to a local buffer through a simple write port. A single start strobe carries a six-bit start address and a word count. The controller first requests the shared memory port and waits for a grant. It then runs one independent read transaction per word and finally releases the port.

The port answers every change the controller makes to its pins with a ready level. The controller holds each serial clock phase until ready is high, so the serial rate is set entirely by the port and not by the system clock. If the grant never arrives, the controller gives up after a programmable number of polling intervals, each of a programmable number of clock cycles, and reports failure. Completion is a one-cycle done pulse, with an error flag that is high only on a failed acquisition.

Top module: `seeprom_block_reader`

## Requirements
- R1: A start strobe with a nonzero count raises port_req_o on the next cycle. A cycle with port_ready_i high while requesting grants the port. If ready stays low for POLL_LIMIT x TICK_CYCLES cycles counted from the rise of port_req_o, the controller does the following: it drops port_req_o, pulses done_o and error_o together in that cycle, and writes no word.
- R2: After the grant, every serial step holds cs_o, sclk_o and sdo_o unchanged until a cycle with port_ready_i high. Only that cycle advances the step.
- R3: Each word transaction opens with cs_o and sclk_o rising together while sdo_o is low.
- R4: The next nine bits are driven on sdo_o, in this order: 1, 1, 0, then address bits A5 down to A0. Each bit changes only while sclk_o is low and stays stable while sclk_o is high.
- R5: The controller then runs 17 clock cycles and samples sdi_i in each low phase. The first sample (a leading zero) is discarded, and the remaining 16 samples form the word, MSB first.
- R6: Each transaction ends with cs_o low, after which sclk_o completes exactly one low-high-low pulse before the next transaction or the release.
- R7: The words are read from addresses start, start+1 and so on for count words, wrapping modulo 64. Word n is written once with buf_we_o high and buf_addr_o = n, where n runs from 0 to count-1.
- R8: When the last word's transaction has ended, port_req_o, cs_o, sclk_o and sdo_o are all low in the cycle done_o pulses, and error_o is low. In reset all outputs are low.
- R9: A start strobe that arrives while a run is in progress is ignored, and no second run follows.
- R10: A start strobe with a count of 0 pulses done_o with error_o low in the next cycle and does not request the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| start_addr_i | input | 6 | First EEPROM word address |
| word_count_i | input | 7 | Number of words, 0 to 64 |
| port_ready_i | input | 1 | Grant / step-complete level from the memory port |
| sdi_i | input | 1 | Serial data from the EEPROM |
| port_req_o | output | 1 | Memory port request |
| cs_o | output | 1 | EEPROM chip select |
| sclk_o | output | 1 | EEPROM serial clock |
| sdo_o | output | 1 | Serial data to the EEPROM |
| buf_we_o | output | 1 | Buffer write enable |
| buf_addr_o | output | 6 | Buffer index of the word |
| buf_data_o | output | 16 | Word read from the EEPROM |
| done_o | output | 1 | Run finished, one-cycle pulse |
| error_o | output | 1 | Acquisition timed out, valid with done_o |

## Verification
The bench pushes the grant to the last cycle the timeout allows and then to one cycle later. A timer that is off by one either aborts a run that should succeed or starts a transfer after it should have failed. A run that starts at address 62 crosses the top of the address space, which catches a design that stops or sends a wrong address instead of wrapping. A run of 64 words catches an index that overflows. Random ready stalls expose any step that advances without the port's ready, which would corrupt the bit stream seen by the EEPROM model. A start strobe issued during a run checks that the run's parameters are not overwritten. A count of zero checks that the port is never requested.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_XFER = 2'd2
  } sr_state_e;

  // start bit followed by the two-bit read opcode, sent first
  localparam logic [2:0] RD_PREFIX   = 3'b110;
  localparam int         PREFIX_BITS = 3;

  function automatic int sr_cmd_bits(input int aw);
    return PREFIX_BITS + aw;
  endfunction

  // step layout of one word: select, command bits, receive bits, tail
  function automatic int sr_data_lo(input int aw);
    return 1 + 2 * sr_cmd_bits(aw);
  endfunction

  function automatic int sr_end_lo(input int aw, input int dw);
    return sr_data_lo(aw) + 2 * (dw + 1);
  endfunction

  function automatic int sr_steps(input int aw, input int dw);
    return sr_end_lo(aw, dw) + 3;
  endfunction

endpackage

// File: rtl/sr_acq_timer.sv
module sr_acq_timer #(
  parameter int TICK_CYCLES = 100000,
  parameter int POLL_LIMIT  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int NW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);
  localparam logic [NW-1:0] N_LAST   = NW'(POLL_LIMIT - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [NW-1:0] n_q, n_d;
  logic          tick_c;

  always_comb begin
    tick_c   = (pre_q == PRE_LAST);
    expire_o = run_i && tick_c && (n_q == N_LAST);
    pre_d    = pre_q;
    n_d      = n_q;
    if (!run_i) begin
      pre_d = '0;
      n_d   = '0;
    end else if (tick_c) begin
      pre_d = '0;
      if (!expire_o) n_d = n_q + NW'(1);
    end else begin
      pre_d = pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      n_q   <= '0;
    end else begin
      pre_q <= pre_d;
      n_q   <= n_d;
    end
  end

  AST_TIMER_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> (pre_q == '0 && n_q == '0)); // R1

endmodule

// File: rtl/sr_pin_decode.sv
module sr_pin_decode
  import sr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int STEP_W = 6
) (
  input  logic              active_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              sdo_o
);
  localparam int CMD_BITS = sr_cmd_bits(ADDR_W);
  localparam logic [STEP_W-1:0] DAT_LO_S = STEP_W'(sr_data_lo(ADDR_W));
  localparam logic [STEP_W-1:0] END_LO_S = STEP_W'(sr_end_lo(ADDR_W, DATA_W));

  logic [CMD_BITS-1:0] cmd_c, cmd_sh;
  logic [STEP_W-1:0]   off_c;

  always_comb begin
    cs_o   = 1'b0;
    sclk_o = 1'b0;
    sdo_o  = 1'b0;
    off_c  = '0;
    cmd_c  = {RD_PREFIX, addr_i};
    cmd_sh = '0;
    if (active_i) begin
      if (step_i == '0) begin
        // select together with a clock high phase
        cs_o   = 1'b1;
        sclk_o = 1'b1;
      end else if (step_i < DAT_LO_S) begin
        // command bit pairs: low phase sets data, high phase clocks it
        off_c  = step_i - STEP_W'(1);
        cmd_sh = cmd_c << (off_c >> 1);
        cs_o   = 1'b1;
        sclk_o = off_c[0];
        sdo_o  = cmd_sh[CMD_BITS-1];
      end else if (step_i < END_LO_S) begin
        off_c  = step_i - DAT_LO_S;
        cs_o   = 1'b1;
        sclk_o = off_c[0];
      end else begin
        // deselected tail: low, high, low
        sclk_o = (step_i == END_LO_S + STEP_W'(1));
      end
    end
  end

endmodule

// File: rtl/sr_rx_shift.sv
module sr_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_i) sh_d = {sh_q[DATA_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word_o = sh_q;

endmodule

// File: rtl/seeprom_block_reader.sv
module seeprom_block_reader
  import sr_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int TICK_CYCLES = 100000,
  parameter int POLL_LIMIT  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W:0]   word_count_i,
  input  logic              port_ready_i,
  input  logic              sdi_i,
  output logic              port_req_o,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              buf_we_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              done_o,
  output logic              error_o
);
  localparam int STEPS  = sr_steps(ADDR_W, DATA_W);
  localparam int STEP_W = $clog2(STEPS);
  localparam int CNT_W  = ADDR_W + 1;
  localparam logic [STEP_W-1:0] DAT_LO_S  = STEP_W'(sr_data_lo(ADDR_W));
  localparam logic [STEP_W-1:0] END_LO_S  = STEP_W'(sr_end_lo(ADDR_W, DATA_W));
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  sr_state_e         st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CNT_W-1:0]  idx_q, idx_d, cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d, addr_d;
  logic              req_q, req_d;
  logic              cs_q, sclk_q, sdo_q, cs_d, sclk_d, sdo_d;
  logic              we_q, we_d, done_q, done_d, err_q, err_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d, rx_word;
  logic              expire_c, in_data_c, sample_c, rx_last_c;
  logic [STEP_W-1:0] doff_c;

  sr_acq_timer #(
    .TICK_CYCLES (TICK_CYCLES),
    .POLL_LIMIT  (POLL_LIMIT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_ns),
    .run_i    (st_q == ST_ACQ),
    .expire_o (expire_c)
  );

  // step flags of the current step
  always_comb begin
    doff_c    = step_q - DAT_LO_S;
    in_data_c = (st_q == ST_XFER) && (step_q >= DAT_LO_S) && (step_q < END_LO_S);
    sample_c  = in_data_c && !doff_c[0];
    rx_last_c = in_data_c && (step_q == END_LO_S - STEP_W'(1));
  end

  sr_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_ns),
    .shift_i (sample_c && port_ready_i),
    .bit_i   (sdi_i),
    .word_o  (rx_word)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    base_d  = base_q;
    req_d   = req_q;
    we_d    = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (word_count_i == '0) begin
            done_d = 1'b1;
          end else begin
            st_d   = ST_ACQ;
            req_d  = 1'b1;
            base_d = start_addr_i;
            cnt_d  = word_count_i;
            idx_d  = '0;
            step_d = '0;
          end
        end
      end
      ST_ACQ: begin
        if (port_ready_i) begin
          st_d   = ST_XFER;
          step_d = '0;
        end else if (expire_c) begin
          st_d   = ST_IDLE;
          req_d  = 1'b0;
          done_d = 1'b1;
          err_d  = 1'b1;
        end
      end
      ST_XFER: begin
        if (port_ready_i) begin
          if (rx_last_c) begin
            we_d    = 1'b1;
            waddr_d = idx_q[ADDR_W-1:0];
            wdata_d = rx_word;
          end
          if (step_q == STEP_LAST) begin
            if (idx_q == cnt_q - CNT_W'(1)) begin
              st_d   = ST_IDLE;
              req_d  = 1'b0;
              done_d = 1'b1;
            end else begin
              idx_d  = idx_q + CNT_W'(1);
              step_d = '0;
            end
          end else begin
            step_d = step_q + STEP_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    addr_d = base_d + idx_d[ADDR_W-1:0];
  end

  // pin values of the next step, registered at the edge
  sr_pin_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STEP_W (STEP_W)
  ) u_pins (
    .active_i (st_d == ST_XFER),
    .step_i   (step_d),
    .addr_i   (addr_d),
    .cs_o     (cs_d),
    .sclk_o   (sclk_d),
    .sdo_o    (sdo_d)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q    <= ST_IDLE;
      step_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      req_q   <= 1'b0;
      cs_q    <= 1'b0;
      sclk_q  <= 1'b0;
      sdo_q   <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      step_q  <= step_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      req_q   <= req_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      sdo_q   <= sdo_d;
      we_q    <= we_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign port_req_o = req_q;
  assign cs_o       = cs_q;
  assign sclk_o     = sclk_q;
  assign sdo_o      = sdo_q;
  assign buf_we_o   = we_q;
  assign buf_addr_o = waddr_q;
  assign buf_data_o = wdata_q;
  assign done_o     = done_q;
  assign error_o    = err_q;

  AST_REQ_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_ns)
    cs_o |-> port_req_o); // R1
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_ns)
    error_o |-> done_o); // R1
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_XFER && !port_ready_i) |=> $stable({cs_o, sclk_o, sdo_o})); // R2
  AST_SDO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_ns)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o)); // R4
  AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_ns)
    buf_we_o |-> ({1'b0, buf_addr_o} < cnt_q)); // R7
  AST_RELEASE_ALL: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o |-> !(port_req_o || cs_o || sclk_o || sdo_o)); // R8

endmodule

// File: tb/seeprom_block_reader_bench.sv
module seeprom_block_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 3;
  localparam int LIMIT = 4;
  localparam int LT = TICK * LIMIT;

  logic clk, rst_n, start_i, port_ready_i, sdi_i;
  logic [5:0] start_addr_i;
  logic [6:0] word_count_i;
  logic port_req_o, cs_o, sclk_o, sdo_o, buf_we_o, done_o, error_o;
  logic [5:0] buf_addr_o;
  logic [15:0] buf_data_o;

  seeprom_block_reader #(.TICK_CYCLES(TICK), .POLL_LIMIT(LIMIT)) u_seeprom_block_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .word_count_i(word_count_i), .port_ready_i(port_ready_i), .sdi_i(sdi_i),
    .port_req_o(port_req_o), .cs_o(cs_o), .sclk_o(sclk_o), .sdo_o(sdo_o),
    .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o), .buf_data_o(buf_data_o),
    .done_o(done_o), .error_o(error_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // EEPROM model
  logic [15:0] mem [64];
  int mstate = 0, nb = 0, oc = 0, mw = 0, xf_start = 0;
  logic [7:0] msh = '0;
  logic [15:0] mword = '0;
  logic mdo = 1'b0;
  assign sdi_i = mdo;

  always @(posedge sclk_o or negedge cs_o) begin
    if (!cs_o) begin
      mstate = 0; mdo = 1'b0;
    end else begin
      case (mstate)
        0: if (sdo_o) begin mstate = 1; nb = 0; msh = '0; end
        1: begin
          msh = {msh[6:0], sdo_o};
          nb++;
          if (nb == 8) begin
            chk(msh[7:6] == 2'b10, "R4 read opcode", msh[7:6], 2);
            chk(int'(msh[5:0]) == (xf_start + mw) % 64, "R7 sent address",
                msh[5:0], (xf_start + mw) % 64);
            mword = mem[msh[5:0]];
            mw++;
            mdo = 1'b0;
            mstate = 2; oc = 0;
          end
        end
        default: begin
          mdo = (oc < 16) ? mword[15-oc] : 1'b0;
          oc++;
        end
      endcase
    end
  end

  // monitors and ready driver
  logic p_cs = 0, p_sclk = 0, p_sdo = 0, p_req = 0, rdy_seen = 0;
  int since_req = 1000000, req_rises = 0, tail_cnt = 0, wr_cnt = 0, done_cnt = 0, done_at = 0;
  bit tail_active = 0, last_err = 0;
  logic [15:0] wr_data [64];
  int rdy_mode = 2, grant_at = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (port_req_o && !p_req) begin since_req = 0; req_rises++; end
      else since_req++;
      if (!rdy_seen && p_req && port_req_o)
        chk({cs_o, sclk_o, sdo_o} == {p_cs, p_sclk, p_sdo}, "R2 stall hold",
            {cs_o, sclk_o, sdo_o}, {p_cs, p_sclk, p_sdo});
      if (cs_o && !p_cs) begin
        chk(sclk_o && !sdo_o, "R3 select with clock high", {sclk_o, sdo_o}, 2);
        if (tail_active) chk(tail_cnt == 1, "R6 tail pulse", tail_cnt, 1);
        tail_active = 0;
      end
      if (cs_o && p_cs && sdo_o != p_sdo)
        chk(!sclk_o, "R4 data changes with clock low", sclk_o, 0);
      if (!cs_o && p_cs) begin
        chk(!sclk_o, "R6 deselect with clock low", sclk_o, 0);
        tail_active = 1; tail_cnt = 0;
      end else if (!cs_o && tail_active && sclk_o && !p_sclk) tail_cnt++;
      if (buf_we_o) begin wr_data[buf_addr_o] = buf_data_o; wr_cnt++; end
      if (done_o) begin
        done_cnt++; last_err = error_o; done_at = since_req;
        chk(!(port_req_o | cs_o | sclk_o | sdo_o), "R8 release",
            {port_req_o, cs_o, sclk_o, sdo_o}, 0);
        if (tail_active) chk(tail_cnt == 1, "R6 last tail pulse", tail_cnt, 1);
        tail_active = 0;
      end
    end
    p_cs = cs_o; p_sclk = sclk_o; p_sdo = sdo_o; p_req = port_req_o;
    case (rdy_mode)
      0: port_ready_i = 1'b0;
      1: port_ready_i = ($urandom % 4) != 0;
      3: port_ready_i = port_req_o && (since_req >= grant_at);
      default: port_ready_i = 1'b1;
    endcase
    rdy_seen = port_ready_i;
  end

  task automatic launch(input int sa, input int cnt, input int mode, input int ga);
    rdy_mode = mode; grant_at = ga; xf_start = sa; mw = 0; wr_cnt = 0;
    @(negedge clk);
    start_i = 1'b1; start_addr_i = 6'(sa); word_count_i = 7'(cnt);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_words(input int sa, input int cnt);
    chk(!last_err, "R8 success flag", last_err, 0);
    chk(wr_cnt == cnt, "R7 write count", wr_cnt, cnt);
    for (int i = 0; i < cnt; i++)
      chk(wr_data[i] == mem[(sa + i) % 64], "R5 word data", wr_data[i], mem[(sa + i) % 64]);
  endtask

  task automatic run_ok(input int sa, input int cnt, input int mode);
    int d0;
    d0 = done_cnt;
    launch(sa, cnt, mode, 0);
    wait_done(d0);
    check_words(sa, cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0, r0;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
    start_i = 0; start_addr_i = 0; word_count_i = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    chk({port_req_o, cs_o, sclk_o, sdo_o, buf_we_o, done_o, error_o} == 0,
        "R8 reset outputs low", {port_req_o, cs_o, sclk_o, sdo_o, buf_we_o, done_o, error_o}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    run_ok(0, 1, 2);
    run_ok(5, 3, 1);
    run_ok(62, 4, 1);   // wraps past address 63 (R7)
    run_ok(0, 64, 2);   // full space

    // R1 timeout: grant one cycle too late
    d0 = done_cnt;
    launch(3, 2, 3, LT);
    wait_done(d0);
    chk(last_err, "R1 timeout error", last_err, 1);
    chk(done_at == LT, "R1 timeout cycle", done_at, LT);
    chk(wr_cnt == 0, "R1 no write on timeout", wr_cnt, 0);

    // R1 grant in the last allowed cycle
    d0 = done_cnt;
    launch(7, 2, 3, LT - 1);
    wait_done(d0);
    check_words(7, 2);

    // R10 zero count
    r0 = req_rises;
    rdy_mode = 2;
    @(negedge clk);
    start_i = 1; start_addr_i = 9; word_count_i = 0;
    @(negedge clk);
    chk(done_o && !error_o, "R10 zero count done", {done_o, error_o}, 2);
    start_i = 0;
    repeat (5) @(negedge clk);
    chk(req_rises == r0, "R10 no request", req_rises - r0, 0);

    // R9 start ignored while busy
    d0 = done_cnt; r0 = req_rises;
    launch(20, 3, 2, 0);
    repeat (30) @(negedge clk);
    start_i = 1; start_addr_i = 40; word_count_i = 2;
    @(negedge clk);
    start_i = 0;
    wait_done(d0);
    check_words(20, 3);
    repeat (100) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 single completion", done_cnt - d0, 1);
    chk(req_rises == r0 + 1, "R9 single request", req_rises - r0, 1);

    for (int t = 0; t < 10; t++) run_ok(int'($urandom % 64), 1 + int'($urandom % 6), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule